// File: doc/BRIEF.md
# Page Protection Key Checker

This block rules on one memory access per cycle. It combines the ordinary page permissions with a second layer of permissions that does not depend on the page table. The translated page entry supplies a small key. The key selects one domain in a per-thread permission register. That domain holds an access-disable bit and a write-disable bit. The access is allowed only when both layers agree.

The key layer applies only to pages marked as user pages. Accesses to such pages are checked the same way whether they come from user mode or supervisor mode. Pages marked as supervisor pages ignore the key entirely.

The verdict is computed combinationally and registered, so it appears one cycle after the request. When the access is refused, the verdict carries a fault code. The code distinguishes a missing page, a legacy protection failure and a key failure. It also records whether the access was a write and whether it came from user mode.

A write port loads the permission register. Page-table walking, translation caching and fault delivery are handled elsewhere.

Top module: `pkey_gate`

## Requirements
- R1: A request with `req_valid` high in one cycle gives `rsp_valid` high in the next cycle. A cycle without a request gives `rsp_valid`, `rsp_allow` and `rsp_code` all zero in the next cycle, and all three are zero after reset.
- R2: An access to a page with `pg_present` low is refused. Code bit 0 (page present) and bit 3 (key fault) are clear, and the key is not consulted.
- R3: A user-mode access (`acc_user`=1) to a present page with `pg_user`=0 is refused as a legacy fault, with code bit 0 set and bit 3 clear.
- R4: A write (`acc_write`=1) to a present page with `pg_writable`=0 is refused as a legacy fault in either mode, with code bit 0 set and bit 3 clear.
- R5: The permission register is 32 bits wide. Key k selects bit 2k as access-disable and bit 2k+1 as write-disable, and no other bit affects that access.
- R6: On a user page, a set access-disable bit refuses both reads and writes.
- R7: On a user page, a set write-disable bit refuses writes and has no effect on reads.
- R8: On a supervisor page (`pg_user`=0), the permission register has no effect on the verdict.
- R9: Supervisor-mode accesses to user pages receive the same key checks as user-mode accesses.
- R10: Code bit 3 is set only when the legacy checks pass and the key check fails. When both layers fail, the legacy fault is reported and bit 3 stays clear.
- R11: The fault code is 4 bits wide: bit 0 is page present, bit 1 is write access, bit 2 is user mode, and bit 3 is key fault. On a refused access, bits 1 and 2 copy `acc_write` and `acc_user`. An allowed access gives an all-zero code.
- R12: The permission register resets to zero, which allows every domain. A request in the same cycle as a register write is checked against the old contents, and a request in any later cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| perm_wr_en | input | 1 | Load the permission register |
| perm_wr_data | input | 32 | New permission register contents |
| req_valid | input | 1 | An access is presented this cycle |
| req_key | input | 4 | Protection key from the translated page entry |
| pg_present | input | 1 | Page is present |
| pg_writable | input | 1 | Page allows writes |
| pg_user | input | 1 | Page is a user page |
| acc_write | input | 1 | Access is a write (0 = read) |
| acc_user | input | 1 | Access comes from user mode |
| rsp_valid | output | 1 | Verdict valid, one cycle after the request |
| rsp_allow | output | 1 | Access is allowed |
| rsp_code | output | 4 | Fault code, zero when allowed |

## Verification
For each of several permission patterns, every key is combined with all 32 settings of present, writable, page-user, write and mode. The patterns are: all clear, all access-disable, all write-disable, all set, and a mixed pattern with a different pair per domain.

Each pattern separates a different case:
- All-clear isolates the legacy checks.
- All access-disable and all write-disable separate the two permission bits.
- All-set shows that legacy faults take precedence over key faults.
- The mixed pattern shows that each key selects its own bit pair and no neighbour's.

A final sequence presents a request in the same cycle as a register write, and again in the following cycle, to pin down when a new permission value takes effect.

// File: rtl/pkey_pkg.sv
package pkey_pkg;
    localparam int CODE_W     = 4;
    localparam int EC_PRESENT = 0;
    localparam int EC_WRITE   = 1;
    localparam int EC_USER    = 2;
    localparam int EC_KEY     = 3;

    typedef struct packed {
        logic              valid;
        logic              allow;
        logic [CODE_W-1:0] code;
    } verdict_t;
endpackage

// File: rtl/pkey_perm_reg.sv
module pkey_perm_reg #(
    parameter int PERM_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PERM_W-1:0] wr_data,
    output logic [PERM_W-1:0] perm
);
    logic [PERM_W-1:0] perm_d, perm_q;

    always_comb begin
        perm_d = perm_q;
        if (wr_en) perm_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) perm_q <= '0;
        else        perm_q <= perm_d;
    end

    assign perm = perm_q;
endmodule

// File: rtl/pkey_lookup.sv
module pkey_lookup #(
    parameter int NUM_KEYS = 16,
    parameter int KEY_W    = $clog2(NUM_KEYS),
    parameter int PERM_W   = 2 * NUM_KEYS
) (
    input  logic [PERM_W-1:0] perm,
    input  logic [KEY_W-1:0]  key,
    output logic              acc_dis,
    output logic              wr_dis
);
    logic [NUM_KEYS-1:0] ad_vec;
    logic [NUM_KEYS-1:0] wd_vec;

    for (genvar i = 0; i < NUM_KEYS; i++) begin : g_dom
        assign ad_vec[i] = perm[2*i];
        assign wd_vec[i] = perm[2*i+1];
    end

    assign acc_dis = ad_vec[key];
    assign wr_dis  = wd_vec[key];
endmodule

// File: rtl/pkey_decide.sv
module pkey_decide
    import pkey_pkg::*;
(
    input  logic              present,
    input  logic              writable,
    input  logic              page_user,
    input  logic              is_write,
    input  logic              from_user,
    input  logic              acc_dis,
    input  logic              wr_dis,
    output logic              allow,
    output logic [CODE_W-1:0] code
);
    logic legacy_bad;
    logic key_bad;

    always_comb begin
        legacy_bad = (from_user && !page_user) || (is_write && !writable);
        key_bad    = page_user && (acc_dis || (is_write && wr_dis));
        allow      = 1'b0;
        code       = '0;
        if (!present) begin
            code[EC_WRITE] = is_write;
            code[EC_USER]  = from_user;
        end else if (legacy_bad || key_bad) begin
            code[EC_PRESENT] = 1'b1;
            code[EC_WRITE]   = is_write;
            code[EC_USER]    = from_user;
            code[EC_KEY]     = !legacy_bad;
        end else begin
            allow = 1'b1;
        end
    end
endmodule

// File: rtl/pkey_gate.sv
module pkey_gate
    import pkey_pkg::*;
#(
    parameter int NUM_KEYS = 16,
    parameter int KEY_W    = $clog2(NUM_KEYS),
    parameter int PERM_W   = 2 * NUM_KEYS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              perm_wr_en,
    input  logic [PERM_W-1:0] perm_wr_data,
    input  logic              req_valid,
    input  logic [KEY_W-1:0]  req_key,
    input  logic              pg_present,
    input  logic              pg_writable,
    input  logic              pg_user,
    input  logic              acc_write,
    input  logic              acc_user,
    output logic              rsp_valid,
    output logic              rsp_allow,
    output logic [CODE_W-1:0] rsp_code
);
    logic [PERM_W-1:0] perm;
    logic              acc_dis, wr_dis;
    logic              dec_allow;
    logic [CODE_W-1:0] dec_code;
    verdict_t          verdict_d, verdict_q;

    pkey_perm_reg #(.PERM_W(PERM_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (perm_wr_en),
        .wr_data (perm_wr_data),
        .perm    (perm)
    );

    pkey_lookup #(.NUM_KEYS(NUM_KEYS), .KEY_W(KEY_W), .PERM_W(PERM_W)) u_lookup (
        .perm    (perm),
        .key     (req_key),
        .acc_dis (acc_dis),
        .wr_dis  (wr_dis)
    );

    pkey_decide u_decide (
        .present   (pg_present),
        .writable  (pg_writable),
        .page_user (pg_user),
        .is_write  (acc_write),
        .from_user (acc_user),
        .acc_dis   (acc_dis),
        .wr_dis    (wr_dis),
        .allow     (dec_allow),
        .code      (dec_code)
    );

    always_comb begin
        verdict_d = '0;
        if (req_valid) begin
            verdict_d.valid = 1'b1;
            verdict_d.allow = dec_allow;
            verdict_d.code  = dec_code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) verdict_q <= '0;
        else        verdict_q <= verdict_d;
    end

    assign rsp_valid = verdict_q.valid;
    assign rsp_allow = verdict_q.allow;
    assign rsp_code  = verdict_q.code;
endmodule

// File: rtl/pkey_gate_chk.sv
module pkey_gate_chk
    import pkey_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              pg_present,
    input logic              pg_user,
    input logic              acc_write,
    input logic              acc_user,
    input logic              rsp_valid,
    input logic              rsp_allow,
    input logic [CODE_W-1:0] rsp_code
);
    // R1
    valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_allow && rsp_code == '0));

    // R2
    absent_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pg_present) |=>
            (!rsp_allow && !rsp_code[EC_PRESENT] && !rsp_code[EC_KEY]));

    // R3
    user_on_sup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && pg_present && acc_user && !pg_user) |=>
            (!rsp_allow && rsp_code[EC_PRESENT] && !rsp_code[EC_KEY]));

    // R8
    sup_page_nokey_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !pg_user) |=> !rsp_code[EC_KEY]);

    // R11
    allow_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> (rsp_valid && rsp_code == '0));

    // R11
    fault_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_allow ||
            (rsp_code[EC_WRITE] == $past(acc_write) && rsp_code[EC_USER] == $past(acc_user))));
endmodule

bind pkey_gate pkey_gate_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .pg_present (pg_present),
    .pg_user    (pg_user),
    .acc_write  (acc_write),
    .acc_user   (acc_user),
    .rsp_valid  (rsp_valid),
    .rsp_allow  (rsp_allow),
    .rsp_code   (rsp_code)
);

// File: tb/pkey_gate_test.sv
module pkey_gate_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        perm_wr_en;
    logic [31:0] perm_wr_data;
    logic        req_valid;
    logic [3:0]  req_key;
    logic        pg_present, pg_writable, pg_user, acc_write, acc_user;
    logic        rsp_valid, rsp_allow;
    logic [3:0]  rsp_code;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model_perm;

    always #2.5 clk = ~clk;

    pkey_gate uut (
        .clk(clk), .rst_n(rst_n), .perm_wr_en(perm_wr_en), .perm_wr_data(perm_wr_data),
        .req_valid(req_valid), .req_key(req_key), .pg_present(pg_present),
        .pg_writable(pg_writable), .pg_user(pg_user), .acc_write(acc_write),
        .acc_user(acc_user), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_code(rsp_code)
    );

    // expected {valid, allow, code[3:0]} from the requirements
    function automatic logic [5:0] expect_v(input logic [31:0] pr, input int k,
        input logic p, input logic w, input logic u, input logic wr, input logic um);
        logic ad, wd, leg, kf;
        ad  = pr[2*k];        // R5
        wd  = pr[2*k+1];
        leg = (um && !u) || (wr && !w);
        kf  = u && (ad || (wr && wd));
        if (!p)            return {1'b1, 1'b0, 1'b0, um, wr, 1'b0};
        if (leg)           return {1'b1, 1'b0, 1'b0, um, wr, 1'b1};
        if (kf)            return {1'b1, 1'b0, 1'b1, um, wr, 1'b1};
        return {1'b1, 1'b1, 4'b0000};
    endfunction

    function automatic string tag_of(input logic [31:0] pr, input int k,
        input logic p, input logic w, input logic u, input logic wr, input logic um);
        if (!p)                               return "R2";
        if (um && !u)                         return "R3";
        if (wr && !w)                         return (u && pr[2*k]) ? "R10" : "R4";
        if (!u)                               return "R8";
        if (!um)                              return "R9";
        if (pr[2*k])                          return "R6";
        if (pr[2*k+1])                        return "R7";
        return "R5";
    endfunction

    task automatic compare(input logic [5:0] exp, input string tag);
        checks++;
        if ({rsp_valid, rsp_allow, rsp_code} !== exp) begin
            fails++;
            $display("FAIL %s: got valid=%0b allow=%0b code=%04b, expected valid=%0b allow=%0b code=%04b",
                     tag, rsp_valid, rsp_allow, rsp_code, exp[5], exp[4], exp[3:0]);
        end
    endtask

    task automatic load_perm(input logic [31:0] v);
        perm_wr_en   = 1'b1;
        perm_wr_data = v;
        req_valid    = 1'b0;
        @(negedge clk);
        perm_wr_en   = 1'b0;
        model_perm   = v;
    endtask

    task automatic sweep();
        for (int k = 0; k < 16; k++) begin
            for (int c = 0; c < 32; c++) begin
                logic [4:0] b;
                b = c[4:0];
                req_valid = 1'b1; req_key = k[3:0];
                pg_present = b[0]; pg_writable = b[1]; pg_user = b[2];
                acc_write = b[3]; acc_user = b[4];
                @(negedge clk);
                compare(expect_v(model_perm, k, b[0], b[1], b[2], b[3], b[4]),
                        tag_of(model_perm, k, b[0], b[1], b[2], b[3], b[4]));
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        compare(6'b000000, "R1 idle");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; perm_wr_en = 1'b0; perm_wr_data = '0; req_valid = 1'b0;
        req_key = '0; pg_present = 1'b0; pg_writable = 1'b0; pg_user = 1'b0;
        acc_write = 1'b0; acc_user = 1'b0; model_perm = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare(6'b000000, "R1 reset");

        // R12: reset contents allow all domains
        sweep();
        load_perm(32'h5555_5555);   // R6 all access-disable
        sweep();
        load_perm(32'hAAAA_AAAA);   // R7 all write-disable
        sweep();
        load_perm(32'hFFFF_FFFF);   // R10 precedence
        sweep();
        load_perm(32'h1B4E_93C6);   // R5 mixed per-domain pairs
        sweep();

        // R12: same-cycle write uses old contents, next request sees new
        load_perm(32'h0000_0000);
        perm_wr_en = 1'b1; perm_wr_data = 32'h0000_0040;   // key 3 access-disable
        req_valid = 1'b1; req_key = 4'd3; pg_present = 1'b1; pg_writable = 1'b1;
        pg_user = 1'b1; acc_write = 1'b0; acc_user = 1'b1;
        @(negedge clk);
        compare({1'b1, 1'b1, 4'b0000}, "R12 old value");
        perm_wr_en = 1'b0;
        @(negedge clk);
        compare({1'b1, 1'b0, 4'b1101}, "R12 new value");
        req_valid = 1'b0;
        @(negedge clk);
        compare(6'b000000, "R1 idle end");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule